// File: doc/BRIEF.md
# Tone Duration Steering Validator

This block stands behind a dual-tone detector and decides when a detected tone pair counts as a real key press. The detector supplies an early signal-condition flag and a 4-bit code. Inside the block, a saturating up/down timer advances on a 1 ms tick. It counts up while the evidence agrees with a state change and down while it disagrees. A tone is registered only after the flag has been high for the acquire time in net ticks. Once registered, the tone is released only after the flag has been low for the pause time in net ticks. As a result, short bursts are rejected and short dropouts inside a held tone are ignored.

On registration the block does three things. It loads the code into a holding latch. It raises a guard-time output while the early flag stays high. After a fixed settle delay in clock cycles, it raises a delayed steering flag that tells downstream logic the latch is valid. The latched code is driven onto the output bus only while an output-enable input is high, and the bus reads zero otherwise; this stands in for a tri-state pad.

All interfaces are plain level signals. The detector never waits on this block and the consumer samples when it likes, so there is no valid/ready handshake and no back-pressure.

Top module: `tone_steer_validator`

## Requirements
- R1: In the waiting state, a tone is registered only on the tick where the net count of ticks with `est_i` high reaches ACQ_TICKS. The count goes up on a tick with `est_i` high, goes down on a tick with `est_i` low, and never falls below zero. A tick occurs once every CLKS_PER_TICK clock cycles.
- R2: On registration the value of `code_i` is captured in the latch. The latch keeps that value until the next registration, including across a release.
- R3: `gt_o` is high exactly while a tone is registered and `est_i` is high.
- R4: `std_o` rises exactly SETTLE_CYC clock cycles after the edge at which the tone is registered.
- R5: In the registered state, the tone is released on the tick where the net count of ticks with `est_i` low reaches PAUSE_TICKS. Release clears `std_o` in the same cycle, and the timer restarts at zero.
- R6: A dropout of `est_i` that lasts fewer than PAUSE_TICKS ticks does not release the tone, and `std_o` stays high through it.
- R7: `code_o` equals the latch while `oe_i` is 1 and reads 0 while `oe_i` is 0. `oe_i` has no effect on any other behaviour.
- R8: While `rst_n` is low, `code_o`, `gt_o` and `std_o` are 0 and the latch holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| est_i | input | 1 | Early signal-condition flag from the detector |
| code_i | input | CODE_W | Code of the detected tone pair |
| oe_i | input | 1 | Output bus enable |
| code_o | output | CODE_W | Latched code, or 0 while disabled |
| gt_o | output | 1 | Guard-time output |
| std_o | output | 1 | Delayed steering flag |

## Verification
The latch, the registered and released state and the timer all change on the clock edge of a tick, and `std_o` follows SETTLE_CYC edges after registration. `gt_o` and `code_o` are combinational in `est_i` and `oe_i` and react within the same cycle. The bench keeps a cycle-exact arithmetic model that is stepped on every rising edge, compares all three outputs at every falling edge, and changes inputs one time unit after that falling edge. Scenario checks hold each input level for a whole number of tick periods, so each window contains an exact, known number of ticks regardless of prescaler phase.

// File: rtl/stv_pkg.sv
package stv_pkg;
  typedef enum logic {
    PH_WAIT = 1'b0,
    PH_HELD = 1'b1
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/stv_tick_gen.sv
module stv_tick_gen #(
  parameter int CLKS_PER_TICK = 200000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (CLKS_PER_TICK <= 1) begin : g_every
      logic run_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
      end
      assign tick_o = run_q;
    end else begin : g_div
      localparam int PW = $clog2(CLKS_PER_TICK);
      localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/stv_hyst_timer.sv
module stv_hyst_timer
  import stv_pkg::*;
#(
  parameter int ACQ_TICKS   = 40,
  parameter int PAUSE_TICKS = 40,
  parameter int CNT_W       = $clog2(max2(ACQ_TICKS, PAUSE_TICKS) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             est_i,
  output logic             held_o,
  output logic             acq_o,
  output logic             rel_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_TICKS - 1);
  localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(PAUSE_TICKS - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             toward;
  logic [CNT_W-1:0] last;
  logic             fire;

  // Evidence "toward" a phase change: high flag while waiting, low flag while held.
  assign toward = (ph_q == PH_HELD) ? ~est_i : est_i;
  assign last   = (ph_q == PH_HELD) ? REL_LAST : ACQ_LAST;
  assign fire   = tick_i && toward && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_WAIT;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (fire) begin
        cnt_q <= '0;
        ph_q  <= (ph_q == PH_HELD) ? PH_WAIT : PH_HELD;
      end else if (toward) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign held_o = (ph_q == PH_HELD);
  assign acq_o  = fire && (ph_q == PH_WAIT);
  assign rel_o  = fire && (ph_q == PH_HELD);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/stv_settle_dly.sv
module stv_settle_dly #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clr_i,
  output logic std_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] START = SW'(SETTLE_CYC);

  logic [SW-1:0] left_q;
  logic          std_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      std_q  <= 1'b0;
    end else if (clr_i) begin
      left_q <= '0;
      std_q  <= 1'b0;
    end else begin
      if (left_q != '0) begin
        left_q <= left_q - 1'b1;
        if (left_q == SW'(1)) std_q <= 1'b1;
      end
      if (load_i) left_q <= START;
    end
  end

  assign std_o = std_q;
endmodule

// File: rtl/stv_code_latch.sv
module stv_code_latch #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              oe_i,
  output logic [CODE_W-1:0] latch_o,
  output logic [CODE_W-1:0] bus_o
);
  logic [CODE_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (load_i) lat_q <= code_i;
  end

  for (genvar b = 0; b < CODE_W; b++) begin : g_gate
    assign bus_o[b] = oe_i & lat_q[b];
  end

  assign latch_o = lat_q;
endmodule

// File: rtl/tone_steer_validator.sv
module tone_steer_validator
  import stv_pkg::*;
#(
  parameter int CLKS_PER_TICK = 200000,
  parameter int ACQ_TICKS     = 40,
  parameter int PAUSE_TICKS   = 40,
  parameter int SETTLE_CYC    = 4,
  parameter int CODE_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              est_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              oe_i,
  output logic [CODE_W-1:0] code_o,
  output logic              gt_o,
  output logic              std_o
);
  localparam int CNT_W = $clog2(max2(ACQ_TICKS, PAUSE_TICKS) + 1);

  logic              tick;
  logic              held;
  logic              acq;
  logic              rel;
  logic [CNT_W-1:0]  tmr_cnt;
  logic [CODE_W-1:0] latch_q;

  stv_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  stv_hyst_timer #(
    .ACQ_TICKS(ACQ_TICKS), .PAUSE_TICKS(PAUSE_TICKS), .CNT_W(CNT_W)
  ) tmr_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .est_i(est_i),
    .held_o(held), .acq_o(acq), .rel_o(rel), .cnt_o(tmr_cnt)
  );

  stv_settle_dly #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
    .clk(clk), .rst_n(rst_n), .load_i(acq), .clr_i(rel), .std_o(std_o)
  );

  stv_code_latch #(.CODE_W(CODE_W)) latch_i (
    .clk(clk), .rst_n(rst_n), .load_i(acq), .code_i(code_i),
    .oe_i(oe_i), .latch_o(latch_q), .bus_o(code_o)
  );

  assign gt_o = held & est_i;
endmodule

// File: rtl/stv_checker.sv
module stv_checker #(
  parameter int ACQ_TICKS   = 40,
  parameter int PAUSE_TICKS = 40,
  parameter int CODE_W      = 4,
  parameter int CNT_W       = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              est_i,
  input logic              tick,
  input logic              held,
  input logic              std_o,
  input logic [CODE_W-1:0] latch_q,
  input logic [CNT_W-1:0]  tmr_cnt
);
  localparam int MAXL = (ACQ_TICKS > PAUSE_TICKS) ? ACQ_TICKS : PAUSE_TICKS;

  // R1
  acq_on_high_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> ($past(tick) && $past(est_i)));

  // R1
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tmr_cnt) < MAXL);

  // R2
  latch_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(latch_q));

  // R4
  std_within_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    std_o |-> held);

  // R5
  rel_on_low_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> ($past(tick) && !$past(est_i)));
endmodule

bind tone_steer_validator stv_checker #(
  .ACQ_TICKS(ACQ_TICKS), .PAUSE_TICKS(PAUSE_TICKS), .CODE_W(CODE_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .est_i(est_i), .tick(tick), .held(held),
  .std_o(std_o), .latch_q(latch_q), .tmr_cnt(tmr_cnt)
);

// File: tb/tone_steer_validator_tb_top.sv
`timescale 1ns/1ps
module tone_steer_validator_tb_top;
  localparam int CPT = 3;
  localparam int ACQ = 5;
  localparam int PAU = 4;
  localparam int SET = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       est = 1'b0;
  logic       oe = 1'b0;
  logic [3:0] code = 4'd0;
  logic [3:0] code_o;
  logic       gt_o;
  logic       std_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tone_steer_validator #(
    .CLKS_PER_TICK(CPT), .ACQ_TICKS(ACQ), .PAUSE_TICKS(PAU),
    .SETTLE_CYC(SET), .CODE_W(4)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .est_i(est), .code_i(code), .oe_i(oe),
    .code_o(code_o), .gt_o(gt_o), .std_o(std_o)
  );

  // Arithmetic reference, stepped once per rising edge.
  int         m_p, m_t, m_s;
  bit         m_hold, m_std, m_tk;
  logic [3:0] m_lat;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_p = 0; m_t = 0; m_s = 0; m_hold = 0; m_std = 0; m_lat = 4'd0;
    end else begin
      m_tk = (m_p == CPT - 1);
      m_p  = m_tk ? 0 : m_p + 1;
      if (m_s != 0) begin
        if (m_s == 1) m_std = 1;
        m_s--;
      end
      if (m_tk) begin
        if (!m_hold) begin
          if (est) begin
            if (m_t == ACQ - 1) begin
              m_hold = 1; m_lat = code; m_t = 0; m_s = SET;
            end else m_t++;
          end else if (m_t > 0) m_t--;
        end else begin
          if (!est) begin
            if (m_t == PAU - 1) begin
              m_hold = 0; m_t = 0; m_s = 0; m_std = 0;
            end else m_t++;
          end else if (m_t > 0) m_t--;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison and scenario observers.
  int  cyc = 0;
  int  gt_rise_cyc = -1;
  int  std_rise_cyc = -1;
  bit  seen_std, std_fell, prev_std, prev_gt;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check(code_o == (oe ? m_lat : 4'd0), "R7 bus vs latch", code_o, oe ? m_lat : 0);
      check(gt_o == (m_hold && est), "R3 guard time", gt_o, m_hold && est);
      check(std_o == m_std, "R4 delayed steering", std_o, m_std);
      if (std_o) seen_std = 1;
      if (prev_std && !std_o) std_fell = 1;
      if (gt_o && !prev_gt && !prev_std) gt_rise_cyc = cyc;
      if (std_o && !prev_std) std_rise_cyc = cyc;
      prev_std = std_o;
      prev_gt  = gt_o;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  logic [3:0] last_code;

  initial begin
    last_code = 4'd0;
    run(3);
    // R8: outputs quiet in reset, even with enable and flag high
    oe = 1; est = 1;
    run(1);
    check(code_o == 4'd0, "R8 reset bus", code_o, 0);
    check(gt_o == 1'b0, "R8 reset gt", gt_o, 0);
    check(std_o == 1'b0, "R8 reset std", std_o, 0);
    est = 0; oe = 0;
    rst_n = 1;
    run(2);

    // Sweep tone lengths and codes: R1, R2, R4, R7
    for (int c = 0; c < 16; c++) begin
      for (int len = 1; len <= ACQ + 2; len++) begin
        code = 4'(c); oe = c[0]; est = 1;
        seen_std = 0; gt_rise_cyc = -1; std_rise_cyc = -1;
        run(len * CPT);
        est = 0; code = ~4'(c);
        run((PAU + ACQ + 2) * CPT);
        check(seen_std == (len >= ACQ), "R1 registration vs length", seen_std, len >= ACQ);
        if (len >= ACQ) begin
          last_code = 4'(c);
          check(std_rise_cyc - gt_rise_cyc == SET, "R4 settle delay",
                std_rise_cyc - gt_rise_cyc, SET);
        end
        oe = 1; run(1);
        check(code_o == last_code, "R2 latch after tone", code_o, last_code);
        oe = 0; run(1);
        check(code_o == 4'd0, "R7 disabled bus", code_o, 0);
      end
    end

    // Dropout sweep: R6 tolerance, R5 release
    for (int d = 1; d <= PAU + 1; d++) begin
      code = 4'(d + 8); est = 1; oe = 1;
      run(ACQ * CPT + SET + 2);
      check(std_o == 1'b1, "R4 steady tone", std_o, 1);
      std_fell = 0;
      est = 0;
      run(d * CPT);
      est = 1;
      run((ACQ + 1) * CPT + SET + 2);
      check(std_fell == (d >= PAU), "R6 dropout vs pause", std_fell, d >= PAU);
      check(gt_o == 1'b1, "R3 guard after dropout", gt_o, 1);
      check(std_o == 1'b1, "R6 steering after dropout", std_o, 1);
      est = 0;
      run((PAU + 2) * CPT);
      check(std_o == 1'b0, "R5 released", std_o, 0);
      check(gt_o == 1'b0, "R3 guard low after release", gt_o, 0);
      check(code_o == 4'(d + 8), "R2 latch kept after release", code_o, d + 8);
      run(ACQ * CPT);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule